// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's complement operands of `OP_W` bits each and returns a signed product of `2*OP_W` bits. It works over several clock cycles and retires one multiplier bit per cycle using radix-2 Booth recoding. A start pulse captures both operands. The multiplier is placed in the low half of a working register whose high half is cleared, and a guard bit of zero is added below the least significant bit.

On every step the block looks at two bits: the lowest bit of the register and the guard bit. The pair 10 subtracts the multiplicand from the high half. The pair 01 adds it. The pairs 00 and 11 leave the high half as it is. The whole register, guard bit included, then shifts right by one place, and the sign is copied into the top bit. After exactly `OP_W` steps the register holds the product. The block raises a one-cycle completion pulse and keeps the result unchanged until the next accepted start.

The high-half add/subtract is done at `OP_W+1` bits. This keeps the sum from overflowing when the multiplicand is the most negative value. A parameter selects how subtraction is built: either as inversion plus carry-in, or as a plain difference.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset (active low) is asserted, and in the first cycle after it is released, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A high `start_i` seen at a rising edge while `busy_o` is 0 loads the operands. `busy_o` reads 1 after that same edge.
- R3: After an accepted start, `busy_o` stays high for exactly `OP_W` cycles. At the edge where it falls, `done_o` rises for exactly one cycle.
- R4: When `done_o` is high, `product_o` equals the signed product of the captured multiplicand and multiplier, as a `2*OP_W`-bit two's complement value.
- R5: Extreme operands give exact results: the most negative value times itself gives +2^(2*OP_W-2), and 0, +1, -1 and the most positive value are handled correctly in every combination.
- R6: A `start_i` pulse while `busy_o` is 1 is ignored. Neither the running result nor the cycle count of the operation changes.
- R7: While `busy_o` is 0 and no start is accepted, `product_o` keeps its value from one cycle to the next.
- R8: A start asserted in the same cycle that `done_o` is high is accepted. The new operation then runs with full timing and a correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | OP_W | Signed multiplicand, captured on an accepted start |
| mplier_i | input | OP_W | Signed multiplier, captured on an accepted start |
| busy_o | output | 1 | High while the step sequence runs |
| done_o | output | 1 | One-cycle pulse when the product is final |
| product_o | output | 2*OP_W | Signed product; holds its value while idle |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a running sequence. It must be dropped without disturbing the result or the cycle count. The bench starts one multiplication, waits a few steps, and then pulses start with different operands. It checks that the original product comes out after exactly `OP_W` busy cycles. A separate test asserts start in the exact cycle of the completion pulse, to show that a back-to-back start is accepted.

// File: rtl/booth_pkg.sv
package booth_pkg;

   typedef enum logic [1:0] {
      BOOTH_NOP = 2'd0,
      BOOTH_ADD = 2'd1,
      BOOTH_SUB = 2'd2
   } booth_op_e;

endpackage

// File: rtl/booth_pair_decode.sv
module booth_pair_decode
   import booth_pkg::*;
(
   input  logic      lsb_i,
   input  logic      guard_i,
   output booth_op_e op_o
);

   always_comb begin
      unique case ({lsb_i, guard_i})
         2'b10:   op_o = BOOTH_SUB;
         2'b01:   op_o = BOOTH_ADD;
         default: op_o = BOOTH_NOP;
      endcase
   end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
   import booth_pkg::*;
#(
   parameter int W          = 8,
   parameter bit INVERT_SUB = 1'b1
) (
   input  logic [W-1:0] acc_i,
   input  logic [W-1:0] mcand_i,
   input  booth_op_e    op_i,
   output logic [W:0]   sum_o
);

   localparam int EW = W + 1;

   logic [EW-1:0] acc_ext;
   logic [EW-1:0] mc_ext;

   assign acc_ext = {acc_i[W-1], acc_i};
   assign mc_ext  = {mcand_i[W-1], mcand_i};

   generate
      if (INVERT_SUB) begin : g_inv
         logic [EW-1:0] operand;
         logic [EW-1:0] cin_ext;
         always_comb begin
            unique case (op_i)
               BOOTH_SUB: operand = ~mc_ext;
               BOOTH_ADD: operand = mc_ext;
               default:   operand = '0;
            endcase
            cin_ext = {{(EW-1){1'b0}}, (op_i == BOOTH_SUB)};
         end
         assign sum_o = acc_ext + operand + cin_ext;
      end else begin : g_direct
         always_comb begin
            unique case (op_i)
               BOOTH_SUB: sum_o = acc_ext - mc_ext;
               BOOTH_ADD: sum_o = acc_ext + mc_ext;
               default:   sum_o = acc_ext;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/booth_step_ctr.sv
module booth_step_ctr #(
   parameter int STEPS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic step_i,
   output logic last_o
);

   localparam int CW = $clog2(STEPS + 1);

   logic [CW-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load_i) begin
         remain_q <= CW'(STEPS);
      end else if (step_i && remain_q != '0) begin
         remain_q <= remain_q - CW'(1);
      end
   end

   assign last_o = (remain_q == CW'(1));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
   import booth_pkg::*;
#(
   parameter int OP_W       = 8,
   parameter bit INVERT_SUB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OP_W-1:0]   mcand_i,
   input  logic [OP_W-1:0]   mplier_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [2*OP_W-1:0] product_o
);

   localparam int PW = 2 * OP_W;

   generate
      if (OP_W < 2) begin : g_bad_width
         $error("booth_seq_mult: OP_W must be at least 2");
      end
   endgenerate

   logic [OP_W-1:0] hi_q;
   logic [OP_W-1:0] lo_q;
   logic            guard_q;
   logic [OP_W-1:0] mcand_q;
   logic            busy_q;
   logic            done_q;

   logic            accept;
   logic            last_step;
   booth_op_e       step_op;
   logic [OP_W:0]   hi_sum;

   assign accept = start_i && !busy_q;

   booth_pair_decode u_dec (
      .lsb_i   (lo_q[0]),
      .guard_i (guard_q),
      .op_o    (step_op)
   );

   booth_addsub #(
      .W          (OP_W),
      .INVERT_SUB (INVERT_SUB)
   ) u_addsub (
      .acc_i   (hi_q),
      .mcand_i (mcand_q),
      .op_i    (step_op),
      .sum_o   (hi_sum)
   );

   booth_step_ctr #(
      .STEPS (OP_W)
   ) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .step_i (busy_q),
      .last_o (last_step)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q    <= '0;
         lo_q    <= '0;
         guard_q <= 1'b0;
         mcand_q <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            hi_q    <= '0;
            lo_q    <= mplier_i;
            guard_q <= 1'b0;
            mcand_q <= mcand_i;
            busy_q  <= 1'b1;
         end else if (busy_q) begin
            hi_q    <= hi_sum[OP_W:1];
            lo_q    <= {hi_sum[0], lo_q[OP_W-1:1]};
            guard_q <= lo_q[0];
            if (last_step) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o    = busy_q;
   assign done_o    = done_q;
   assign product_o = PW'({hi_q, lo_q});

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
   parameter int OP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [OP_W-1:0]   mcand_i,
   input logic [OP_W-1:0]   mplier_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [2*OP_W-1:0] product_o
);

   localparam int PW = 2 * OP_W;
   localparam int CW = $clog2(OP_W + 2);

   logic [OP_W-1:0] a_q, b_q;
   logic [CW-1:0]   busy_cnt;
   logic            armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q      <= '0;
         b_q      <= '0;
         busy_cnt <= '0;
         armed    <= 1'b0;
      end else begin
         armed <= 1'b1;
         if (start_i && !busy_o) begin
            a_q      <= mcand_i;
            b_q      <= mplier_i;
            busy_cnt <= '0;
         end else if (busy_o) begin
            busy_cnt <= busy_cnt + CW'(1);
         end
      end
   end

   p_idle_after_reset_r1: assert property (@(posedge clk)
      disable iff (!rst_n) !armed |-> (!busy_o && !done_o && product_o == '0));

   p_start_sets_busy_r2: assert property (@(posedge clk)
      disable iff (!rst_n) (start_i && !busy_o) |=> busy_o);

   p_done_single_r3: assert property (@(posedge clk)
      disable iff (!rst_n) done_o |=> !done_o);

   p_busy_length_r3: assert property (@(posedge clk)
      disable iff (!rst_n) done_o |-> (busy_cnt == CW'(OP_W) && !busy_o));

   p_product_r4: assert property (@(posedge clk)
      disable iff (!rst_n) done_o |->
         ($signed(product_o) == $signed(PW'($signed(a_q)) * PW'($signed(b_q)))));

   p_hold_idle_r7: assert property (@(posedge clk)
      disable iff (!rst_n) (armed && !busy_o && !start_i) |=> $stable(product_o));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.OP_W(OP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .mcand_i   (mcand_i),
   .mplier_i  (mplier_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .product_o (product_o)
);

// File: tb/booth_seq_mult_bench.sv
module booth_seq_mult_bench;

   localparam int N  = 8;
   localparam int PW = 2 * N;
   localparam int NV = 12;

   localparam logic [PW-1:0] VEC [NV] = '{
      16'h02FD, 16'h0000, 16'h0101, 16'hFFFF,
      16'h7F7F, 16'h55AA, 16'hFF01, 16'h64F9,
      16'hCEC4, 16'h0F03, 16'hAA55, 16'h3333
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [N-1:0]  mcand_i = '0;
   logic [N-1:0]  mplier_i = '0;
   logic          busy_o;
   logic          done_o;
   logic [PW-1:0] product_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   booth_seq_mult #(.OP_W(N)) u_booth_seq_mult (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .mcand_i   (mcand_i),
      .mplier_i  (mplier_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .product_o (product_o)
   );

   function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
      logic signed [PW-1:0] sa, sb;
      sa = PW'($signed(a));
      sb = PW'($signed(b));
      return sa * sb;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // Drives a start in the current negedge slot; returns busy cycles and product.
   task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                         input int intrude_at, output int cycles,
                         output logic [PW-1:0] prod);
      mcand_i  = a;
      mplier_i = b;
      start_i  = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cycles = 0;
      for (int g = 0; g < 4 * N && !done_o; g++) begin
         if (busy_o) cycles++;
         if (intrude_at > 0 && cycles == intrude_at) begin
            mcand_i  = ~a;
            mplier_i = 8'h7F;
            start_i  = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
      prod = product_o;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      int cyc;
      logic [PW-1:0] p, held;

      repeat (3) @(negedge clk);
      check("R1 busy in reset", busy_o, 0);
      check("R1 done in reset", done_o, 0);
      check("R1 product in reset", product_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy after release", busy_o, 0);
      check("R1 product after release", product_o, 0);

      // R4 table walk; R2 and R3 timing checked on each entry
      for (int i = 0; i < NV; i++) begin
         mcand_i  = VEC[i][PW-1:N];
         mplier_i = VEC[i][N-1:0];
         start_i  = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         check("R2 busy after start", busy_o, 1);
         cyc = 0;
         for (int g = 0; g < 4 * N && !done_o; g++) begin
            if (busy_o) cyc++;
            @(negedge clk);
         end
         check("R3 busy length", cyc, N);
         check("R3 done pulse", done_o, 1);
         check("R4 product", product_o, ref_mul(VEC[i][PW-1:N], VEC[i][N-1:0]));
         @(negedge clk);
         check("R3 done falls", done_o, 0);
      end

      // R5 extremes
      run_op(8'h80, 8'h80, 0, cyc, p);
      check("R5 min*min", p, 16'h4000);
      @(negedge clk);
      run_op(8'h80, 8'h7F, 0, cyc, p);
      check("R5 min*max", p, ref_mul(8'h80, 8'h7F));
      @(negedge clk);
      run_op(8'h7F, 8'h80, 0, cyc, p);
      check("R5 max*min", p, ref_mul(8'h7F, 8'h80));
      @(negedge clk);
      run_op(8'h80, 8'hFF, 0, cyc, p);
      check("R5 min*-1", p, 16'h0080);
      @(negedge clk);

      // R6 start while busy is ignored
      run_op(8'h13, 8'hE5, 3, cyc, p);
      check("R6 cycles unchanged", cyc, N);
      check("R6 result unchanged", p, ref_mul(8'h13, 8'hE5));

      // R8 back-to-back start in the done cycle
      check("R8 done visible", done_o, 1);
      run_op(8'hF6, 8'h0C, 0, cyc, p);
      check("R8 cycles", cyc, N);
      check("R8 result", p, ref_mul(8'hF6, 8'h0C));

      // R7 hold while idle, operand inputs toggling
      held = product_o;
      for (int k = 0; k < 6; k++) begin
         mcand_i  = 8'(k * 37);
         mplier_i = 8'(k * 91);
         @(negedge clk);
      end
      check("R7 product held", product_o, held);
      check("R7 still idle", busy_o, 0);

      // R1 reset mid-operation
      mcand_i = 8'h21; mplier_i = 8'h43; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 busy cleared", busy_o, 0);
      check("R1 product cleared", product_o, 0);

      finish_run();
   end

endmodule